// File: doc/BRIEF.md
# Grid Path Segment Builder

This block keeps track of one operand path on a small rectangular grid of cells. The path begins at a fixed path-origin cell and is made of straight segments laid end to end. A new segment always starts where the current path ends. Each clock cycle an active cell may issue one path command. An extend command appends a segment whose length is the number of set bits in a length field, running in one of four axis directions. An erase command removes the newest segment. The block reports the cell where the path currently ends, which is where an operand would be found.

Two cell maps are inputs to the block. One marks which cells are path-origin cells and the other marks which cells are accumulator cells. Cell (row, col) is bit `row*COLS + col` of each map. When a segment runs into an origin cell, the segment stops at that cell. A segment cannot start from an accumulator cell. If a segment would run off the grid, it is cut short at the edge. The segments are held on a stack of parameter depth. The top module reports the stack occupancy, the length and direction of the newest segment, and a flag that is raised when an extend command is refused because the stack is full.

Top module: `gp_path_builder`

## Requirements
- R1: After reset the path is empty: `seg_count` is 0, the termination equals `origin_row`/`origin_col`, `overflow` is 0, and `last_len` and `last_dir` read 0.
- R2: On an accepted extend command (`cmd_erase`=0), the requested length is the number of 1 bits in `cmd_len`. `cmd_dir` selects the unit step: 00 = row+1, 01 = col+1, 10 = row-1, 11 = col-1. The new termination is the old termination plus length times the step, and `last_len`/`last_dir` report the new segment.
- R3: Each new segment starts at the current termination. A pushed segment raises `seg_count` by one.
- R4: An erase command (`cmd_erase`=1) on a non-empty path removes the newest segment. `seg_count` falls by one and the termination returns to that segment's start cell. Erasing the only segment returns the termination to the origin.
- R5: An erase command on an empty path leaves the termination and `seg_count` unchanged.
- R6: If a step lands on a cell marked in `origin_map`, the segment ends there with its length cut to the steps taken. While a non-empty path ends on an origin cell, extend commands have no effect.
- R7: While the termination is a cell marked in `accum_map`, extend commands have no effect.
- R8: A segment that would leave the grid stops at the last in-grid cell. An extend command whose effective length is 0 (no 1 bits, or already at the edge in that direction) has no effect.
- R9: An extend command with non-zero effective length while `seg_count` equals DEPTH is ignored and sets `overflow`. Any erase command clears `overflow`. `seg_count` never exceeds DEPTH.
- R10: While `cmd_valid` is 0 no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| origin_row | input | ROW_W | Row of the owning origin cell (held constant) |
| origin_col | input | COL_W | Column of the owning origin cell (held constant) |
| origin_map | input | ROWS*COLS | Origin-cell marks, bit row*COLS+col |
| accum_map | input | ROWS*COLS | Accumulator-cell marks, bit row*COLS+col |
| cmd_valid | input | 1 | A path command is present this cycle |
| cmd_erase | input | 1 | 1 = erase newest segment, 0 = extend |
| cmd_len | input | LEN_BITS | Length bits; set-bit count is the length |
| cmd_dir | input | 2 | Segment direction |
| term_row | output | ROW_W | Row of the path termination |
| term_col | output | COL_W | Column of the path termination |
| seg_count | output | CNT_W | Segments on the stack |
| last_len | output | LEN_W | Length of newest segment, 0 when empty |
| last_dir | output | 2 | Direction of newest segment, 0 when empty |
| overflow | output | 1 | An extend was refused because the stack was full |

## Verification
The assertions assume that `origin_row`/`origin_col` stay fixed from reset onward and name an in-grid cell. They also assume that no cell is marked in both maps. The stack and termination checks further assume that the maps do not change while a command is being taken. The bench sets the maps only while `cmd_valid` is low and always keeps its own origin cell marked as an origin. It draws accumulator cells only from cells that are not origins. The origin coordinates are constants in the bench.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef enum logic [1:0] {
    DIR_ROW_UP  = 2'b00,
    DIR_COL_UP  = 2'b01,
    DIR_ROW_DN  = 2'b10,
    DIR_COL_DN  = 2'b11
  } dir_e;

  function automatic int dir_drow(input logic [1:0] d);
    case (d)
      DIR_ROW_UP: return 1;
      DIR_ROW_DN: return -1;
      default:    return 0;
    endcase
  endfunction

  function automatic int dir_dcol(input logic [1:0] d);
    case (d)
      DIR_COL_UP: return 1;
      DIR_COL_DN: return -1;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/gp_len_count.sv
module gp_len_count #(
  parameter int W  = 7,
  parameter int OW = 3
) (
  input  logic [W-1:0]  bits,
  output logic [OW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + OW'(bits[i]);
    end
  end
endmodule

// File: rtl/gp_walker.sv
module gp_walker #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int LEN_BITS = 7,
  parameter int LEN_W    = 3
) (
  input  logic [ROW_W-1:0]     start_row,
  input  logic [COL_W-1:0]     start_col,
  input  logic [1:0]           dir,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [ROWS*COLS-1:0] origin_map,
  output logic [ROW_W-1:0]     end_row,
  output logic [COL_W-1:0]     end_col,
  output logic [LEN_W-1:0]     eff_len
);
  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = $clog2(CELLS);

  int   r, c, dr, dc, n;
  logic stop;

  always_comb begin
    r    = int'(start_row);
    c    = int'(start_col);
    dr   = gp_pkg::dir_drow(dir);
    dc   = gp_pkg::dir_dcol(dir);
    n    = 0;
    stop = 1'b0;
    for (int k = 1; k <= LEN_BITS; k++) begin
      if (!stop && k <= int'(req_len)) begin
        if (r + dr < 0 || r + dr >= ROWS || c + dc < 0 || c + dc >= COLS) begin
          stop = 1'b1;
        end else begin
          r = r + dr;
          c = c + dc;
          n = k;
          if (origin_map[IDX_W'(r * COLS + c)]) stop = 1'b1;
        end
      end
    end
    end_row = ROW_W'(r);
    end_col = COL_W'(c);
    eff_len = LEN_W'(n);
  end
endmodule

// File: rtl/gp_seg_stack.sv
module gp_seg_stack #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ROW_W-1:0] push_row,
  input  logic [COL_W-1:0] push_col,
  input  logic [1:0]       push_dir,
  input  logic [LEN_W-1:0] push_len,
  output logic [CNT_W-1:0] count,
  output logic [ROW_W-1:0] top_row,
  output logic [COL_W-1:0] top_col,
  output logic [1:0]       top_dir,
  output logic [LEN_W-1:0] top_len
);
  localparam int EW = ROW_W + COL_W + 2 + LEN_W;

  logic [DEPTH*EW-1:0] flat;
  logic [EW-1:0]       top_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [EW-1:0] ent;
    always_ff @(posedge clk) begin
      if (!rst_n) ent <= '0;
      else if (push && count == CNT_W'(i)) ent <= {push_row, push_col, push_dir, push_len};
    end
    assign flat[i*EW +: EW] = ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (push) count <= count + 1'b1;
    else if (pop)  count <= count - 1'b1;
  end

  always_comb begin
    top_ent = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CNT_W'(i + 1)) top_ent = flat[i*EW +: EW];
    end
  end

  assign {top_row, top_col, top_dir, top_len} = top_ent;
endmodule

// File: rtl/gp_path_builder.sv
module gp_path_builder #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int LEN_BITS = 7,
  parameter int DEPTH    = 4,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int LEN_W   = $clog2(LEN_BITS + 1),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     origin_row,
  input  logic [COL_W-1:0]     origin_col,
  input  logic [ROWS*COLS-1:0] origin_map,
  input  logic [ROWS*COLS-1:0] accum_map,
  input  logic                 cmd_valid,
  input  logic                 cmd_erase,
  input  logic [LEN_BITS-1:0]  cmd_len,
  input  logic [1:0]           cmd_dir,
  output logic [ROW_W-1:0]     term_row,
  output logic [COL_W-1:0]     term_col,
  output logic [CNT_W-1:0]     seg_count,
  output logic [LEN_W-1:0]     last_len,
  output logic [1:0]           last_dir,
  output logic                 overflow
);
  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = $clog2(CELLS);

  logic [LEN_W-1:0] req_len, walk_len;
  logic [ROW_W-1:0] walk_row, top_row;
  logic [COL_W-1:0] walk_col, top_col;
  logic [IDX_W-1:0] term_idx;
  logic             at_origin, at_accum, path_empty, path_full;
  logic             extend_cmd, erase_cmd;
  logic             blocked_evt, push_evt, pop_evt, ovf_evt;

  gp_len_count #(.W(LEN_BITS), .OW(LEN_W)) u_len (
    .bits (cmd_len),
    .ones (req_len)
  );

  gp_walker #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W),
    .LEN_BITS(LEN_BITS), .LEN_W(LEN_W)
  ) u_walk (
    .start_row  (term_row),
    .start_col  (term_col),
    .dir        (cmd_dir),
    .req_len    (req_len),
    .origin_map (origin_map),
    .end_row    (walk_row),
    .end_col    (walk_col),
    .eff_len    (walk_len)
  );

  gp_seg_stack #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .pop      (pop_evt),
    .push_row (term_row),
    .push_col (term_col),
    .push_dir (cmd_dir),
    .push_len (walk_len),
    .count    (seg_count),
    .top_row  (top_row),
    .top_col  (top_col),
    .top_dir  (last_dir),
    .top_len  (last_len)
  );

  assign term_idx    = IDX_W'(int'(term_row) * COLS + int'(term_col));
  assign at_origin   = origin_map[term_idx];
  assign at_accum    = accum_map[term_idx];
  assign path_empty  = (seg_count == '0);
  assign path_full   = (seg_count == CNT_W'(DEPTH));
  assign extend_cmd  = cmd_valid && !cmd_erase;
  assign erase_cmd   = cmd_valid && cmd_erase;

  assign blocked_evt = extend_cmd && (at_accum || (at_origin && !path_empty));
  assign push_evt    = extend_cmd && !blocked_evt && (walk_len != '0) && !path_full;
  assign ovf_evt     = extend_cmd && !blocked_evt && (walk_len != '0) && path_full;
  assign pop_evt     = erase_cmd && !path_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_row <= origin_row;
      term_col <= origin_col;
    end else if (push_evt) begin
      term_row <= walk_row;
      term_col <= walk_col;
    end else if (pop_evt) begin
      term_row <= top_row;
      term_col <= top_col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (ovf_evt)   overflow <= 1'b1;
    else if (erase_cmd) overflow <= 1'b0;
  end
endmodule

// File: rtl/gp_path_builder_sva.sv
module gp_path_builder_sva #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int LEN_W = 3,
  parameter int CNT_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_erase,
  input logic [ROW_W-1:0] origin_row,
  input logic [COL_W-1:0] origin_col,
  input logic [ROW_W-1:0] term_row,
  input logic [COL_W-1:0] term_col,
  input logic [CNT_W-1:0] seg_count,
  input logic [LEN_W-1:0] last_len,
  input logic [LEN_W-1:0] walk_len,
  input logic             overflow,
  input logic             push_evt,
  input logic             pop_evt,
  input logic             ovf_evt,
  input logic             blocked_evt
);
  assert_empty_at_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_count == '0) |-> (term_row == origin_row && term_col == origin_col));

  assert_len_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (last_len == $past(walk_len)));

  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (seg_count == $past(seg_count) + 1'b1));

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (seg_count == $past(seg_count) - 1'b1));

  assert_empty_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_erase && seg_count == '0) |=>
      (seg_count == '0 && $stable(term_row) && $stable(term_col)));

  assert_blocked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> ($stable(term_row) && $stable(term_col) && $stable(seg_count)));

  assert_overflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (overflow && $stable(seg_count) && $stable(term_row) && $stable(term_col)));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_count <= CNT_W'(DEPTH));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(seg_count) && $stable(term_row) && $stable(term_col)
                    && $stable(overflow)));

  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_evt, pop_evt, ovf_evt}));
endmodule

bind gp_path_builder gp_path_builder_sva #(
  .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_erase   (cmd_erase),
  .origin_row  (origin_row),
  .origin_col  (origin_col),
  .term_row    (term_row),
  .term_col    (term_col),
  .seg_count   (seg_count),
  .last_len    (last_len),
  .walk_len    (walk_len),
  .overflow    (overflow),
  .push_evt    (push_evt),
  .pop_evt     (pop_evt),
  .ovf_evt     (ovf_evt),
  .blocked_evt (blocked_evt)
);

// File: tb/gp_path_builder_test.sv
module gp_path_builder_test;
  localparam int ROWS = 8, COLS = 8, LB = 7, DEPTH = 4;
  localparam int CELLS = ROWS * COLS;
  localparam logic [2:0] OR_ROW = 3'd3, OR_COL = 3'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CELLS-1:0] omap = '0, amap = '0;
  logic cmd_valid = 1'b0, cmd_erase = 1'b0;
  logic [LB-1:0] cmd_len = '0;
  logic [1:0] cmd_dir = '0;
  logic [2:0] term_row, term_col, seg_count, last_len;
  logic [1:0] last_dir;
  logic overflow;

  int n_checks = 0, n_fail = 0;

  int m_cnt, m_tr, m_tc, m_ovf;
  int m_sr[DEPTH], m_sc[DEPTH], m_len[DEPTH], m_dir[DEPTH];

  always #10ns clk = ~clk;

  gp_path_builder #(.ROWS(ROWS), .COLS(COLS), .LEN_BITS(LB), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .origin_row(OR_ROW), .origin_col(OR_COL),
    .origin_map(omap), .accum_map(amap), .cmd_valid(cmd_valid),
    .cmd_erase(cmd_erase), .cmd_len(cmd_len), .cmd_dir(cmd_dir),
    .term_row(term_row), .term_col(term_col), .seg_count(seg_count),
    .last_len(last_len), .last_dir(last_dir), .overflow(overflow)
  );

  function automatic logic is_org(int r, int c); return omap[r*COLS + c]; endfunction
  function automatic logic is_acc(int r, int c); return amap[r*COLS + c]; endfunction

  // Reference walk: clip by edge distance first, then look for the first origin cell.
  task automatic ref_walk(input int r, input int c, input int d, input int want,
                          output int er, output int ec, output int len,
                          output bit halted, output bit clipped);
    int room, dr, dc;
    case (d)
      0: begin room = ROWS - 1 - r; dr = 1;  dc = 0;  end
      1: begin room = COLS - 1 - c; dr = 0;  dc = 1;  end
      2: begin room = r;            dr = -1; dc = 0;  end
      default: begin room = c;      dr = 0;  dc = -1; end
    endcase
    clipped = (want > room);
    len = clipped ? room : want;
    halted = 1'b0;
    for (int k = 1; k <= len; k++) begin
      if (!halted && is_org(r + k*dr, c + k*dc)) begin
        halted = 1'b1;
        len = k;
      end
    end
    er = r + len*dr;
    ec = c + len*dc;
  endtask

  task automatic model_reset();
    m_cnt = 0; m_tr = OR_ROW; m_tc = OR_COL; m_ovf = 0;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "term_row", int'(term_row), m_tr);
    check(tag, "term_col", int'(term_col), m_tc);
    check(tag, "seg_count", int'(seg_count), m_cnt);
    check(tag, "overflow", int'(overflow), m_ovf);
    check(tag, "last_len", int'(last_len), m_cnt > 0 ? m_len[m_cnt-1] : 0);
    check(tag, "last_dir", int'(last_dir), m_cnt > 0 ? m_dir[m_cnt-1] : 0);
  endtask

  // One command: drive at negedge, model it, sample a quarter period after the edge.
  task automatic step(input logic v, input logic e, input logic [LB-1:0] lb,
                      input logic [1:0] d, input string forced_tag);
    string tag;
    int er, ec, len;
    bit halted, clipped;
    @(negedge clk);
    cmd_valid = v; cmd_erase = e; cmd_len = lb; cmd_dir = d;
    tag = "R2";
    if (!v) tag = "R10";
    else if (e) begin
      tag = (m_cnt == 0) ? "R5" : "R4";
      m_ovf = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        m_tr = m_sr[m_cnt]; m_tc = m_sc[m_cnt];
      end
    end else if (is_acc(m_tr, m_tc)) tag = "R7";
    else if (is_org(m_tr, m_tc) && m_cnt > 0) tag = "R6";
    else begin
      ref_walk(m_tr, m_tc, int'(d), $countones(lb), er, ec, len, halted, clipped);
      if (len == 0) tag = "R8";
      else if (m_cnt == DEPTH) begin tag = "R9"; m_ovf = 1; end
      else begin
        tag = halted ? "R6" : (clipped ? "R8" : "R3");
        m_sr[m_cnt] = m_tr; m_sc[m_cnt] = m_tc;
        m_len[m_cnt] = len; m_dir[m_cnt] = int'(d);
        m_cnt++;
        m_tr = er; m_tc = ec;
      end
    end
    if (forced_tag != "") tag = forced_tag;
    @(posedge clk);
    #5ns;
    check_all(tag);
  endtask

  task automatic set_maps(input logic [CELLS-1:0] o, input logic [CELLS-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b0;
    omap = o | (CELLS'(1) << (OR_ROW*COLS + OR_COL));
    amap = a & ~omap;
  endtask

  initial begin : watchdog
    #(200000 * 20ns);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [CELLS-1:0] ro, ra;
    void'($urandom(32'd20240611));
    model_reset();
    set_maps('0, '0);
    repeat (3) @(posedge clk);
    #5ns;
    check_all("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5ns;
    check_all("R1");

    // R2: three set bits, column up: (3,3) -> (3,6)
    step(1, 0, 7'b0010110, 2'b01, "R2");
    // R3: chained from (3,6), two bits row up -> (5,6)
    step(1, 0, 7'b0000011, 2'b00, "R3");
    // R8: seven bits row up, clipped at row 7
    step(1, 0, 7'b1111111, 2'b00, "R8");
    // R8: at the edge, nothing happens
    step(1, 0, 7'b0000001, 2'b00, "R8");
    // R4: erase returns to (5,6)
    step(1, 1, 7'b0, 2'b00, "R4");
    // R10: idle with data on the bus
    step(0, 0, 7'b1111111, 2'b10, "R10");
    // R8: zero set bits
    step(1, 0, 7'b0000000, 2'b10, "R8");
    step(1, 1, 7'b0, 2'b00, "R4");
    step(1, 1, 7'b0, 2'b00, "R4");
    // R5: erase when empty
    step(1, 1, 7'b0, 2'b00, "R5");

    // R6: origin at (3,5) halts a four-step segment after two steps
    set_maps(CELLS'(1) << (3*COLS + 5), '0);
    step(1, 0, 7'b1111000, 2'b01, "R6");
    step(1, 0, 7'b0000001, 2'b00, "R6");
    step(1, 1, 7'b0, 2'b00, "R4");

    // R7: accumulator at (3,5) may end a path but not start a segment
    set_maps('0, CELLS'(1) << (3*COLS + 5));
    step(1, 0, 7'b0000011, 2'b01, "R7");
    step(1, 0, 7'b0000001, 2'b00, "R7");
    step(1, 1, 7'b0, 2'b00, "R4");

    // R9: fill the stack, then overflow, then clear by erase
    set_maps('0, '0);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 7'b0000001, 2'b00, "R3");
    step(1, 0, 7'b0000001, 2'b01, "R9");
    step(0, 0, 7'b0, 2'b00, "R10");
    step(1, 1, 7'b0, 2'b00, "R9");
    for (int i = 0; i < DEPTH; i++) step(1, 1, 7'b0, 2'b00, "R4");

    // Random phase with sparse random maps
    for (int phase = 0; phase < 6; phase++) begin
      ro = '0; ra = '0;
      for (int b = 0; b < CELLS; b++) begin
        ro[b] = ($urandom_range(0, 15) == 0);
        ra[b] = ($urandom_range(0, 15) == 0);
      end
      set_maps(ro, ra);
      for (int i = 0; i < 400; i++) begin
        step(($urandom_range(0, 9) != 0),
             ($urandom_range(0, 99) < 35),
             LB'($urandom),
             2'($urandom),
             "");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule